// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between six external interrupt pins and an interrupt controller. Each pin is first brought into the clock domain by a two-stage synchronizer. It then passes through a digital glitch filter that only takes on a new level once the synchronized pin has held that level for a programmable number of clocks. On each level the filter accepts, the block raises a request pulse one clock long, but only if the new level matches the edge that channel is set to detect. The synchronized pin levels are also brought out unfiltered, so software can read the pins as ordinary port inputs.

Channels 1 to 4 each have a programmable edge. Channels 0 and 5 react only to falling edges. Channel 0 shares its pin with a general-purpose port. While its enable bit is clear, the pin acts only as a port input and never raises a request.

One 8-bit control register holds every setting: the channel 0 enable, the four edge bits and the filter length code. The interrupt controller's priority and vectoring logic sits downstream and is not part of this block.

Top module: `extint_cond`

## Requirements
- R1: After reset, `cfg_rdata` is 8'h00, `irq_o` is all zero and `level_o` is all ones (the idle pin level). Pins held at the idle level during and after reset raise no request.
- R2: A write with `cfg_we` high stores `cfg_wdata`. Bit 0 is the channel 0 enable, bits 4:1 are the edge selects of channels 1 to 4 (bit k for channel k), and bits 7:6 are the filter length code. Bit 5 is reserved: it ignores writes and always reads 0.
- R3: `level_o[i]` equals `pin_i[i]` delayed by two clock edges.
- R4: The filter length N is 1, 4, 8 or 16 for codes 0, 1, 2 and 3. A pin excursion held for N or more clocks is accepted. One held for fewer than N clocks raises no request.
- R5: When an accepted level change matches the selected edge, `irq_o[i]` goes high after the (N+2)-th rising clock edge that follows the pin change. It stays high for exactly one clock.
- R6: On channels 1 to 4, an edge-select bit of 0 selects rising edges and a bit of 1 selects falling edges. An edge of the other direction raises no request.
- R7: Channels 0 and 5 request on falling edges only and ignore rising edges.
- R8: While bit 0 is 0, channel 0 raises no request, and `level_o[0]` still tracks the pin.
- R9: Rewriting the edge selects or the filter length while the pins are steady raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| irq_o | output | 6 | One-clock request pulse per channel |
| level_o | output | 6 | Synchronized pin levels |

## Verification
The hardest cases to reach are the filter threshold boundaries. A pulse exactly N clocks wide must be accepted, and one only N-1 clocks wide must be dropped, at every length code. The bench drives pin pulses of width N and N-1 on each channel, for each length code and both edge settings. It counts request pulses and times them from the clock where the pin changed, so an error of one clock in either the filter or the synchronizer shows up. A separate stage holds every pin low and then rewrites the polarity and length fields. This checks that changing the configuration alone never creates a request.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int unsigned NUM_CH  = 6;
    localparam int unsigned MAX_LEN = 16;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN);

    // Control register, bit 0 at the right
    typedef struct packed {
        logic [1:0] nr_sel;     // filter length code
        logic       rsvd;       // reads zero
        logic [3:0] fall_sel;   // edge select, channels 1..4
        logic       ch0_en;     // channel 0 feeds the request path
    } ctl_t;

    localparam int unsigned REG_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        NR_LEN1  = 2'd0,
        NR_LEN4  = 2'd1,
        NR_LEN8  = 2'd2,
        NR_LEN16 = 2'd3
    } nr_code_e;

    // Terminal count of the stability counter (length minus one)
    function automatic logic [CNT_W-1:0] stable_last(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (nr_code_e'(code))
            NR_LEN1:  r = CNT_W'(0);
            NR_LEN4:  r = CNT_W'(3);
            NR_LEN8:  r = CNT_W'(7);
            default:  r = CNT_W'(MAX_LEN - 1);
        endcase
        return r;
    endfunction

    // Falling-edge select for a channel; outer channels are fixed falling
    function automatic logic ch_falls(input int unsigned ch, input ctl_t c);
        logic r;
        case (ch)
            1:       r = c.fall_sel[0];
            2:       r = c.fall_sel[1];
            3:       r = c.fall_sel[2];
            4:       r = c.fall_sel[3];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int unsigned           WIDTH   = 6,
    parameter int unsigned           STAGES  = 2,
    parameter logic [WIDTH-1:0]      RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] warm_q;
            always_ff @(posedge clk) begin
                if (rst)                warm_q <= 2'd0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            // R3: the output is the pin two edges earlier
            a_r3_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
                (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/extint_filter.sv
module extint_filter #(
    parameter int unsigned CNT_W   = 4,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             lvl_o,
    output logic             take_o
);

    logic             flt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differ;
    logic             take;

    assign differ = (lvl_i != flt_q);
    assign take   = differ && (cnt_q >= last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= RST_LVL;
            cnt_q <= '0;
        end else if (!differ) begin
            cnt_q <= '0;
        end else if (take) begin
            flt_q <= lvl_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lvl_o  = flt_q;
    assign take_o = take;

    // R4: a filtered level only moves after a full stability run
    a_r4_run_before_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_q) |-> ($past(cnt_q) >= $past(last_i)));

    // R4: a steady input never moves the filtered level
    a_r4_steady_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(lvl_i) == $past(flt_q)) |-> $stable(flt_q));

endmodule

// File: rtl/extint_edge.sv
module extint_edge #(
    parameter int unsigned NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] take_i,
    input  logic [NUM_CH-1:0] lvl_i,
    input  logic [NUM_CH-1:0] fall_i,
    input  logic [NUM_CH-1:0] gate_i,
    output logic [NUM_CH-1:0] req_o
);

    logic [NUM_CH-1:0] req_q;
    logic [NUM_CH-1:0] hit;

    // new level high qualifies a rising edge, low a falling one
    assign hit = take_i & (lvl_i ^ fall_i) & gate_i;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= hit;
    end

    assign req_o = req_q;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R5: one request never stretches into a second clock
            a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
                req_q[i] |=> !req_q[i]);
        end
    endgenerate

endmodule

// File: rtl/extint_cond.sv
module extint_cond
    import extint_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] irq_o,
    output logic [NUM_CH-1:0] level_o
);

    ctl_t              ctl_q;
    ctl_t              ctl_wr;
    logic [NUM_CH-1:0] sync_lvl;
    logic [NUM_CH-1:0] flt_lvl;
    logic [NUM_CH-1:0] take;
    logic [NUM_CH-1:0] fall_vec;
    logic [NUM_CH-1:0] gate_vec;
    logic [CNT_W-1:0]  last_cnt;

    // control register
    always_comb begin
        ctl_wr      = ctl_t'(cfg_wdata);
        ctl_wr.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (cfg_we) ctl_q <= ctl_wr;
    end

    assign cfg_rdata = REG_W'(ctl_q);
    assign last_cnt  = stable_last(ctl_q.nr_sel);

    // synchronizer
    extint_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (2),
        .RST_VAL({NUM_CH{IDLE_LVL}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(pin_i),
        .q_o(sync_lvl)
    );

    assign level_o = sync_lvl;

    // per-channel filters and edge configuration
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            extint_filter #(
                .CNT_W  (CNT_W),
                .RST_LVL(IDLE_LVL)
            ) u_filter (
                .clk   (clk),
                .rst   (rst),
                .lvl_i (sync_lvl[i]),
                .last_i(last_cnt),
                .lvl_o (flt_lvl[i]),
                .take_o(take[i])
            );
            assign fall_vec[i] = ch_falls(i, ctl_q);
            if (i == 0) begin : g_shared
                assign gate_vec[i] = ctl_q.ch0_en;
            end else begin : g_plain
                assign gate_vec[i] = 1'b1;
            end
        end
    endgenerate

    extint_edge #(
        .NUM_CH(NUM_CH)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .take_i(take),
        .lvl_i (sync_lvl),
        .fall_i(fall_vec),
        .gate_i(gate_vec),
        .req_o (irq_o)
    );

    // R2: reserved bit never holds a one
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[5]);

    // R7: fixed channels only request on a falling edge
    a_r7_ch5_falling: assert property (@(posedge clk) disable iff (rst)
        irq_o[5] |-> !flt_lvl[5]);
    a_r7_ch0_falling: assert property (@(posedge clk) disable iff (rst)
        irq_o[0] |-> !flt_lvl[0]);

    // R8: channel 0 requests only when its enable was set
    a_r8_ch0_gated: assert property (@(posedge clk) disable iff (rst)
        irq_o[0] |-> $past(ctl_q.ch0_en));

    generate
        for (genvar k = 1; k <= 4; k++) begin : g_pol_chk
            // R6: request direction follows the programmed edge
            a_r6_edge_dir: assert property (@(posedge clk) disable iff (rst)
                irq_o[k] |-> (flt_lvl[k] == !$past(fall_vec[k])));
        end
    endgenerate

endmodule

// File: tb/extint_cond_bench.sv
module extint_cond_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [5:0] pin = 6'h3F;
    logic [5:0] irq;
    logic [5:0] level;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int hits   [6];
    int last_t [6];

    always #5 clk = ~clk;

    extint_cond u_extint_cond (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .pin_i    (pin),
        .irq_o    (irq),
        .level_o  (level)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 6; i++) begin
                if (irq[i]) begin
                    hits[i]++;
                    last_t[i] = cyc;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < 6; i++) begin
            hits[i]   = 0;
            last_t[i] = 0;
        end
    endtask

    function automatic int sum_hits();
        int s = 0;
        for (int i = 0; i < 6; i++) s += hits[i];
        return s;
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        int c0;
        int cb;
        int n;
        int w;
        int exp_h;
        int fall;

        clr();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "cfg_rdata", int'(cfg_rdata), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "level", int'(level), 63);
        idle(30);
        chk("R1", "no request from idle pins", sum_hits(), 0);

        // R2: register store and reserved bit
        wr(8'hFF);
        chk("R2", "readback all ones", int'(cfg_rdata), 8'hDF);
        wr(8'h96);
        chk("R2", "readback pattern", int'(cfg_rdata), 8'h96);
        wr(8'h00);
        chk("R2", "readback zero", int'(cfg_rdata), 0);

        // R3: two-edge synchronizer delay on every pin
        for (int ch = 0; ch < 6; ch++) begin
            @(negedge clk);
            pin[ch] = 1'b0;
            @(negedge clk);
            chk("R3", "level one edge after drop", int'(level[ch]), 1);
            @(negedge clk);
            chk("R3", "level two edges after drop", int'(level[ch]), 0);
            pin[ch] = 1'b1;
            idle(2);
            chk("R3", "level back high", int'(level[ch]), 1);
            idle(10);
        end

        // R4 R5 R6 R7: sweep length code, channel, polarity, width
        for (int code = 0; code < 4; code++) begin
            n = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
            for (int ch = 0; ch < 6; ch++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int ws = 0; ws < 2; ws++) begin
                        w = (ws == 1) ? n : n - 1;
                        if (w > 0) begin
                            wr({code[1:0], 1'b0, (pol == 1) ? 4'hF : 4'h0, 1'b1});
                            idle(4);
                            clr();
                            pin[ch] = 1'b0;
                            c0 = cyc;
                            idle(w);
                            pin[ch] = 1'b1;
                            cb = cyc;
                            idle(n + 30);
                            fall  = (ch == 0 || ch == 5) ? 1 : pol;
                            exp_h = (w >= n) ? 1 : 0;
                            chk((ch == 0 || ch == 5) ? "R4/R7" : "R4/R6",
                                $sformatf("hits ch%0d code%0d pol%0d w%0d", ch, code, pol, w),
                                hits[ch], exp_h);
                            chk("R6/R7", $sformatf("other channels ch%0d", ch),
                                sum_hits() - hits[ch], 0);
                            if (exp_h == 1) begin
                                chk("R5", $sformatf("latency ch%0d code%0d pol%0d", ch, code, pol),
                                    last_t[ch] - ((fall == 1) ? c0 : cb), n + 2);
                            end
                        end
                    end
                end
            end
        end

        // R8: channel 0 in port mode
        wr(8'h00);
        idle(4);
        clr();
        pin[0] = 1'b0;
        idle(2);
        chk("R8", "port level follows pin", int'(level[0]), 0);
        idle(6);
        pin[0] = 1'b1;
        idle(30);
        chk("R8", "no request while disabled", hits[0], 0);
        chk("R8", "port level back high", int'(level[0]), 1);

        // R9: configuration changes with steady pins
        wr(8'h01);
        pin = 6'h00;
        idle(40);
        clr();
        wr(8'h1F);
        idle(30);
        wr(8'hC1);
        idle(30);
        wr(8'h5F);
        idle(30);
        wr(8'h81);
        idle(30);
        chk("R9", "no request on reconfig, pins low", sum_hits(), 0);
        pin = 6'h3F;
        idle(40);
        clr();
        wr(8'h1F);
        idle(30);
        wr(8'h41);
        idle(30);
        wr(8'hDF);
        idle(30);
        chk("R9", "no request on reconfig, pins high", sum_hits(), 0);

        summary();
        $finish;
    end

endmodule